// File: doc/BRIEF.md
# Addressed SPI Register Slave

This block is a serial control-port slave that gives a host processor read and write access to a small register file over a four-wire SPI link. The link has a select line, a clock, a data-in line and a data-out line. The port runs on its own system clock and is fully asynchronous to the host's serial clock. Every serial input passes through a synchronizer, and the block acts on serial clock edges that it detects in the system clock domain.

Every transaction opens with an address byte. Its upper seven bits must match a fixed chip identity, and its lowest bit selects the direction. A write then carries a register pointer byte, followed by any number of data bytes that land in consecutive registers. A read streams bytes out, starting at the pointer left by earlier traffic. If the identity does not match, the block stays silent until the select line is released. A mode input lets the surrounding chip take the port off the link entirely.

Top module: `spi_addr_regslave`

## Requirements
- R1: After reset, `reg_we` and `miso_oe` are low and the register pointer (`reg_addr`) is 0.
- R2: All bytes are sent MSB first and sampled on rising `sclk`. The first byte holds the chip identity in bits 7..1, which must equal 7'b0010000. Bit 0 is the direction: 0 means write, 1 means read.
- R3: In a write, the byte after the address byte loads the pointer. Each later complete byte gives exactly one single-cycle `reg_we` pulse, with `reg_wdata` set to that byte and `reg_addr` set to the current pointer.
- R4: The pointer advances by one after each data byte, in both directions, and wraps modulo 2^AW.
- R5: A read returns `reg_rdata` at the current pointer, MSB first. Each bit is driven after a falling `sclk` edge so that the host can sample it on the next rising edge.
- R6: `miso_oe` is high only while a read transaction with a matching identity is in progress. It is low at all other times, and it is never high together with `reg_we`.
- R7: When the identity does not match, `miso_oe` stays low, no write occurs and the pointer is unchanged, until `cs_n` rises.
- R8: Raising `cs_n` in the middle of a byte discards the partial byte. The next transaction starts again with an address byte.
- R9: While `spi_en` is low, the port ignores all serial activity: no write, no pointer change, and `miso_oe` stays low.
- R10: The pointer keeps its value between transactions, so a read that follows a pointer-only write starts at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Enables SPI operation; low takes the port off the link |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| reg_addr | output | AW | Register index, equal to the current pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data for the register at `reg_addr` |

## Verification
The main function is driven with several kinds of transaction: multi-byte writes, pointer-only writes followed by reads, and writes and reads that cross the top register index. These separate a pointer that auto-increments and wraps from one that saturates or resets between transactions.

Address bytes that differ from the identity in a single bit, in both directions, show whether the match really covers the whole identity field and whether the output driver stays off. A select release in the middle of a byte, and traffic sent while the port is disabled, show whether stray bits ever reach the register file or the pointer.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = 3;

   typedef enum logic [2:0] {
      PH_ADDR = 3'd0,
      PH_PTR  = 3'd1,
      PH_WR   = 3'd2,
      PH_RD   = 3'd3,
      PH_SKIP = 3'd4
   } phase_t;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame import spi_rs_pkg::*; #(
   parameter int         AW        = 4,
   parameter logic [6:0] CHIP_ADDR = 7'b0010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_s,
   input  logic              mosi_s,
   output logic              sclk_fall,
   output logic [IDX_W-1:0]  bit_idx,
   output phase_t            phase,
   output logic [AW-1:0]     ptr,
   output logic [BYTE_W-1:0] wdata,
   output logic              we
);
   localparam logic [AW-1:0]    PTR_ONE  = AW'(1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

   logic              sclk_q;
   logic              sclk_rise;
   logic [6:0]        sh;
   logic [BYTE_W-1:0] byte_val;

   assign sclk_rise = active &  sclk_s & ~sclk_q;
   assign sclk_fall = active & ~sclk_s &  sclk_q;
   assign byte_val  = {sh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sh      <= '0;
         bit_idx <= '0;
         phase   <= PH_ADDR;
         ptr     <= '0;
         wdata   <= '0;
         we      <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         we     <= 1'b0;
         if (we) ptr <= ptr + PTR_ONE;
         if (!active) begin
            bit_idx <= '0;
            phase   <= PH_ADDR;
         end else if (sclk_rise) begin
            sh      <= byte_val[6:0];
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_idx == IDX_LAST) begin
               unique case (phase)
                  PH_ADDR: begin
                     if (byte_val[7:1] == CHIP_ADDR)
                        phase <= byte_val[0] ? PH_RD : PH_PTR;
                     else
                        phase <= PH_SKIP;
                  end
                  PH_PTR: begin
                     ptr   <= byte_val[AW-1:0];
                     phase <= PH_WR;
                  end
                  PH_WR: begin
                     we    <= 1'b1;
                     wdata <= byte_val;
                  end
                  PH_RD:   ptr <= ptr + PTR_ONE;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/spi_rs_tx.sv
module spi_rs_tx import spi_rs_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              load,
   input  logic [BYTE_W-1:0] rdata,
   output logic              bit_out
);
   logic [BYTE_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_sh <= '0;
      else if (shift_en) tx_sh <= load ? rdata : {tx_sh[BYTE_W-2:0], 1'b0};
   end

   assign bit_out = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_addr_regslave.sv
module spi_addr_regslave import spi_rs_pkg::*; #(
   parameter int         AW          = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] CHIP_ADDR   = 7'b0010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_en,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   output logic [AW-1:0]     reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   localparam int SYNC_W = 4;

   if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
      $error("AW must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] sync_q;
   logic              en_s, mosi_s, sclk_s, cs_s;
   logic              active;
   logic              sclk_fall;
   logic [IDX_W-1:0]  bit_idx;
   phase_t            phase;
   logic              tx_shift, tx_load;

   spi_rs_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_en, mosi, sclk, cs_n}),
      .q     (sync_q)
   );

   assign {en_s, mosi_s, sclk_s, cs_s} = sync_q;
   assign active = en_s & ~cs_s;

   spi_rs_frame #(
      .AW        (AW),
      .CHIP_ADDR (CHIP_ADDR)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .sclk_s    (sclk_s),
      .mosi_s    (mosi_s),
      .sclk_fall (sclk_fall),
      .bit_idx   (bit_idx),
      .phase     (phase),
      .ptr       (reg_addr),
      .wdata     (reg_wdata),
      .we        (reg_we)
   );

   assign tx_shift = sclk_fall && (phase == PH_RD);
   assign tx_load  = (bit_idx == '0);

   spi_rs_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (tx_shift),
      .load     (tx_load),
      .rdata    (reg_rdata),
      .bit_out  (miso)
   );

   assign miso_oe = (phase == PH_RD);
endmodule

// File: rtl/spi_addr_regslave_chk.sv
module spi_addr_regslave_chk import spi_rs_pkg::*; #(
   parameter int AW = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             active,
   input phase_t           phase,
   input logic [IDX_W-1:0] bit_idx,
   input logic             reg_we,
   input logic [AW-1:0]    reg_addr,
   input logic             miso_oe
);
   p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == $past(reg_addr) + AW'(1)));

   p_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !miso_oe);

   p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> (!reg_we && !miso_oe));

   p_abort_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (bit_idx == '0 && phase == PH_ADDR));

   p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !miso_oe);
endmodule

bind spi_addr_regslave spi_addr_regslave_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .active   (active),
   .phase    (phase),
   .bit_idx  (bit_idx),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .miso_oe  (miso_oe)
);

// File: tb/spi_addr_regslave_tb_top.sv
module spi_addr_regslave_tb_top;
   localparam int  AW   = 4;
   localparam int  NREG = 1 << AW;
   localparam time HALF = 32ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spi_en = 1'b1;
   logic          cs_n = 1'b1;
   logic          sclk = 1'b0;
   logic          mosi = 1'b0;
   logic          miso, miso_oe, reg_we;
   logic [AW-1:0] reg_addr;
   logic [7:0]    reg_wdata, reg_rdata;
   logic [7:0]    mem [NREG];

   int n_chk = 0;
   int n_fail = 0;
   logic [AW+7:0] wr_q [$];
   logic [7:0]    rd_q [$];

   always #2ns clk = ~clk;

   spi_addr_regslave #(.AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .cs_n(cs_n), .sclk(sclk),
      .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected writes as strobes appear
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wr_q.size() == 0) begin
            chk(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
         end else begin
            automatic logic [AW+7:0] e = wr_q.pop_front();
            chk({reg_addr, reg_wdata} == e, "R3/R4 write", {reg_addr, reg_wdata}, e);
         end
         mem[reg_addr] = reg_wdata;
      end
   end

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int b = 7; b > 7 - n; b--) begin
         mosi = tx[b];
         #(HALF);
         sclk = 1'b1;
         rx[b] = miso;
         #(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic begin_txn();
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic end_txn();
      #(HALF);
      cs_n = 1'b1;
      #(HALF * 2);
   endtask

   // Driver: write transaction, expected strobes pushed when the port is on
   task automatic do_write(input logic [7:0] addr_byte, input logic [7:0] p,
                           input logic [7:0] d [], input bit expect_wr);
      logic [7:0] rx;
      logic [AW-1:0] a = p[AW-1:0];
      begin_txn();
      spi_bits(addr_byte, 8, rx);
      spi_bits(p, 8, rx);
      foreach (d[i]) begin
         if (expect_wr) wr_q.push_back({a, d[i]});
         a = a + AW'(1);
         spi_bits(d[i], 8, rx);
      end
      end_txn();
      chk(wr_q.size() == 0, "R3 all writes seen", wr_q.size(), 0);
   endtask

   task automatic do_read(input int n, input string req);
      logic [7:0] rx;
      begin_txn();
      spi_bits(8'h21, 8, rx);
      chk(miso_oe == 1'b1, "R2/R6 oe on matched read", miso_oe, 1);
      for (int i = 0; i < n; i++) begin
         spi_bits(8'h00, 8, rx);
         begin
            automatic logic [7:0] e = rd_q.pop_front();
            chk(rx == e, req, rx, e);
         end
      end
      end_txn();
      chk(miso_oe == 1'b0, "R6 oe off after select release", miso_oe, 0);
   endtask

   initial begin
      #(200000 * 4ns);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      for (int i = 0; i < NREG; i++) mem[i] = 8'(8'h40 + 3 * i);
      #13ns;
      chk(reg_we == 1'b0, "R1 we in reset", reg_we, 0);
      chk(miso_oe == 1'b0, "R1 oe in reset", miso_oe, 0);
      chk(reg_addr == '0, "R1 pointer in reset", reg_addr, 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1ns;
      #(HALF * 2);

      // R2/R3: burst write at pointer 3
      do_write(8'h20, 8'h03, '{8'h5A, 8'hC3, 8'h7E}, 1'b1);
      chk(reg_addr == 4'd6, "R4 pointer after burst", reg_addr, 6);

      // R10 + R5: pointer-only write then read from it
      do_write(8'h20, 8'h04, '{}, 1'b0);
      chk(reg_addr == 4'd4, "R10 pointer held", reg_addr, 4);
      rd_q.push_back(8'hC3); rd_q.push_back(8'h7E); rd_q.push_back(8'h52);
      do_read(3, "R5 read data");
      chk(reg_addr == 4'd7, "R4 pointer after read", reg_addr, 7);

      // R4: write across the top index
      do_write(8'h20, 8'h0F, '{8'h11, 8'h22}, 1'b1);
      chk(reg_addr == 4'd1, "R4 wrap on write", reg_addr, 1);

      // R7: identity off by one bit, write and read directions
      do_write(8'h30, 8'h02, '{8'hFF}, 1'b0);
      chk(reg_addr == 4'd1, "R7 pointer untouched", reg_addr, 1);
      begin_txn();
      spi_bits(8'h23, 8, rx);
      spi_bits(8'h00, 8, rx);
      chk(miso_oe == 1'b0, "R7 oe off on mismatched read", miso_oe, 0);
      end_txn();

      // R8: partial byte aborted by select release
      begin_txn();
      spi_bits(8'h20, 8, rx);
      spi_bits(8'h08, 8, rx);
      wr_q.push_back({4'd8, 8'h99});
      spi_bits(8'h99, 8, rx);
      spi_bits(8'hAA, 4, rx);
      end_txn();
      chk(wr_q.size() == 0, "R8 only full byte written", wr_q.size(), 0);
      chk(reg_addr == 4'd9, "R8 pointer after abort", reg_addr, 9);
      rd_q.push_back(8'h5B);
      do_read(1, "R8 fresh transaction after abort");

      // R9: port disabled
      spi_en = 1'b0;
      #(HALF * 2);
      begin_txn();
      spi_bits(8'h21, 8, rx);
      chk(miso_oe == 1'b0, "R9 oe off while disabled", miso_oe, 0);
      end_txn();
      do_write(8'h20, 8'h01, '{8'hEE}, 1'b0);
      chk(reg_addr == 4'd10, "R9 pointer untouched", reg_addr, 10);
      spi_en = 1'b1;
      #(HALF * 2);

      // R4/R5: read across the top index
      do_write(8'h20, 8'h0F, '{}, 1'b0);
      rd_q.push_back(8'h11); rd_q.push_back(8'h22);
      do_read(2, "R4/R5 read wrap");
      chk(reg_addr == 4'd1, "R4 wrap on read", reg_addr, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule